// File: doc/BRIEF.md
# Power Mode Sequencer

This block is the control core that moves a system between its operating and power-saving states. Nine modes are supported: full-speed run, low-power run, sleep, low-power sleep, three stop depths, standby and shutdown. Software selects a target with a 4-bit mode code and a one-cycle enter strobe. The sequencer accepts only the moves that are legal from the current mode and ignores every other request. It then drives the enables for the main regulator, the low-power regulator, the high-speed and low-speed oscillators, the CPU clock gate, the retained SRAM bank and a core low-leakage control.

Each low-power mode has its own set of wake sources, and a source outside that set has no effect. Sleep and stop modes resume without a reset. Standby and shutdown power the core down, so their exit runs a reset sequence of fixed length before run mode is reached again. After each wake the sequencer reports the system clock source and its frequency in MHz, and applies the low-power-run cap and the slow-voltage-range cap. Regulator and oscillator settling is modelled as cycle counters.

Named states: RUN, LPRUN, SLEEP, LPSLEEP, STOP0, STOP1, STOP2, STANDBY, SHUTDOWN, STOPWAKE (settling after stop), RSTSEQ (reset sequence). Named transitions: enter (RUN or LPRUN to a requested mode), sleep-wake (SLEEP to RUN, LPSLEEP to LPRUN), stop-wake (STOPx to STOPWAKE to RUN), deep-wake (STANDBY or SHUTDOWN to RSTSEQ to RUN), lp-exit (LPRUN to RUN).

Top module: `lpm_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, the mode is RUN. In RUN the main regulator, the high-speed oscillator, the low-speed oscillator and the CPU clock are on, the low-power regulator is off, core_rst_n is 1, and the clock is the multispeed RC (clk_src=0) at 4 MHz.
- R2: From RUN, an enter strobe with mode_req 1 (LPRUN), 2 (SLEEP), 4/5/6 (STOP0/1/2), 7 (STANDBY) or 8 (SHUTDOWN) moves the sequencer to that mode one cycle later. Code 3 (LPSLEEP), codes 9 to 15, and any strobe outside RUN and LPRUN are ignored.
- R3: LPRUN and LPSLEEP use the low-power regulator only and report at most 2 MHz. LPSLEEP can be reached only from LPRUN, and an interrupt or event returns it to LPRUN.
- R4: SLEEP keeps the main regulator and oscillators on and gates only the CPU clock. An interrupt or event returns it to RUN on the next cycle. Other sources are ignored.
- R5: When cfg_slow_range is 1, any mode that runs on the main regulator reports at most 26 MHz.
- R6: STOP0 keeps the main regulator on. STOP1 and STOP2 use the low-power regulator, and STOP2 also raises core_lowleak. In all stop modes the high-speed oscillator and the CPU clock are off and the low-speed oscillator stays on.
- R7: A stop mode wakes only on an interrupt, an event or an RTC event, with no reset. It spends STOP_WAKE_CYC cycles in STOPWAKE (main regulator and high-speed oscillator on, CPU gated) and then reaches RUN.
- R8: On stop wake, the clock becomes the 16 MHz RC (clk_src=1, 16 MHz) if cfg_stop_fixed16 is 1, and otherwise the multispeed RC (clk_src=0) at 48 MHz.
- R9: STANDBY turns the main regulator and the high-speed oscillator off. The low-power regulator and ret_bank_en are on only when cfg_ret_bank is 1. STANDBY wakes on the reset pin, the watchdog, a wake pin edge or an RTC event, and interrupts and events are ignored.
- R10: SHUTDOWN turns off every regulator and oscillator, including the low-speed one. It wakes on the reset pin, a wake pin edge or an RTC event, and the watchdog is ignored.
- R11: A standby or shutdown wake holds core_rst_n at 0 for RST_CYC cycles in RSTSEQ and then reaches RUN. The clock is the multispeed RC at 8 MHz after standby and at 4 MHz after shutdown.
- R12: A wake pin edge is a rising edge when cfg_pin_rise is 1 and a falling edge when it is 0. The opposite edge is ignored.
- R13: From LPRUN, only codes 0 (RUN), 3, 5, 6, 7 and 8 are accepted. Returning to RUN restores the clock frequency that was held before LPRUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system or power reset |
| mode_enter | input | 1 | One-cycle strobe that requests a mode change |
| mode_req | input | 4 | Requested mode code |
| wk_irq | input | 1 | Interrupt pending |
| wk_evt | input | 1 | Event pending |
| wk_pin | input | 1 | Wake pin level |
| wk_rst_pin | input | 1 | External reset pin request |
| wk_rtc | input | 1 | RTC wake event |
| wk_wdg | input | 1 | Watchdog reset request |
| cfg_pin_rise | input | 1 | 1: rising wake pin edge, 0: falling |
| cfg_ret_bank | input | 1 | Keep the retained SRAM bank powered in standby |
| cfg_stop_fixed16 | input | 1 | Clock after stop: 1 = 16 MHz RC, 0 = multispeed RC |
| cfg_slow_range | input | 1 | Slow voltage range, caps clock at 26 MHz |
| main_reg_en | output | 1 | Main regulator enable |
| lp_reg_en | output | 1 | Low-power regulator enable |
| hs_osc_en | output | 1 | High-speed oscillators enable |
| ls_osc_en | output | 1 | Low-speed oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate |
| ret_bank_en | output | 1 | Retained SRAM bank supply in standby |
| core_lowleak | output | 1 | Core low-leakage control (deepest stop) |
| core_rst_n | output | 1 | Core reset during the reset sequence |
| clk_src | output | 1 | 0 = multispeed RC, 1 = 16 MHz RC |
| clk_mhz | output | 7 | System clock frequency in MHz, 0 when halted |

## Verification
A wake source can arrive in the same cycle as an enter strobe, and a stop wake can coincide with a change of the clock configuration. The random phase sets strobes, mode codes, every wake line and the configuration bits independently on each cycle, so these collisions happen often. A mode model in the bench then decides which event wins in the current mode: strobes count only in RUN and LPRUN, and wakes count only in their own mode. The post-wake clock is judged against the configuration sampled in the wake cycle itself. Directed cases add a wake pin edge against a stop mode, a watchdog against shutdown and an LPSLEEP request from RUN.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [3:0] {
        ST_RUN      = 4'd0,
        ST_LPRUN    = 4'd1,
        ST_SLEEP    = 4'd2,
        ST_LPSLEEP  = 4'd3,
        ST_STOP0    = 4'd4,
        ST_STOP1    = 4'd5,
        ST_STOP2    = 4'd6,
        ST_STANDBY  = 4'd7,
        ST_SHUTDOWN = 4'd8,
        ST_STOPWAKE = 4'd9,
        ST_RSTSEQ   = 4'd10
    } lpm_state_e;

    localparam logic [3:0] REQ_RUN      = 4'd0;
    localparam logic [3:0] REQ_LPRUN    = 4'd1;
    localparam logic [3:0] REQ_SLEEP    = 4'd2;
    localparam logic [3:0] REQ_LPSLEEP  = 4'd3;
    localparam logic [3:0] REQ_STOP0    = 4'd4;
    localparam logic [3:0] REQ_STOP1    = 4'd5;
    localparam logic [3:0] REQ_STOP2    = 4'd6;
    localparam logic [3:0] REQ_STANDBY  = 4'd7;
    localparam logic [3:0] REQ_SHUTDOWN = 4'd8;

    localparam logic CK_MULTI   = 1'b0;
    localparam logic CK_FIXED16 = 1'b1;
endpackage

// File: rtl/lpm_wake_filter.sv
module lpm_wake_filter
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lpm_state_e state_q,
    input  logic       wk_irq,
    input  logic       wk_evt,
    input  logic       wk_pin,
    input  logic       wk_rst_pin,
    input  logic       wk_rtc,
    input  logic       wk_wdg,
    input  logic       cfg_pin_rise,
    output logic       wake_hit
);
    logic pin_q;
    logic pin_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= wk_pin;
    end

    assign pin_edge = cfg_pin_rise ? (wk_pin & ~pin_q) : (~wk_pin & pin_q);

    // Each mode listens only to its own wake set
    always_comb begin
        unique case (state_q)
            ST_SLEEP, ST_LPSLEEP:         wake_hit = wk_irq | wk_evt;
            ST_STOP0, ST_STOP1, ST_STOP2: wake_hit = wk_irq | wk_evt | wk_rtc;
            ST_STANDBY:                   wake_hit = wk_rst_pin | wk_wdg | pin_edge | wk_rtc;
            ST_SHUTDOWN:                  wake_hit = wk_rst_pin | pin_edge | wk_rtc;
            default:                      wake_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
#(
    parameter int STOP_WAKE_CYC = 4,
    parameter int RST_CYC       = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_enter,
    input  logic [3:0] mode_req,
    input  logic       wake_hit,
    input  logic       cfg_ret_bank,
    output lpm_state_e state_q,
    output lpm_state_e state_d,
    output logic       main_reg_en,
    output logic       lp_reg_en,
    output logic       hs_osc_en,
    output logic       ls_osc_en,
    output logic       cpu_clk_en,
    output logic       ret_bank_en,
    output logic       core_lowleak,
    output logic       core_rst_n
);
    localparam int MAX_CYC = (STOP_WAKE_CYC > RST_CYC) ? STOP_WAKE_CYC : RST_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (mode_enter) begin
                    case (mode_req)
                        REQ_LPRUN:    state_d = ST_LPRUN;
                        REQ_SLEEP:    state_d = ST_SLEEP;
                        REQ_STOP0:    state_d = ST_STOP0;
                        REQ_STOP1:    state_d = ST_STOP1;
                        REQ_STOP2:    state_d = ST_STOP2;
                        REQ_STANDBY:  state_d = ST_STANDBY;
                        REQ_SHUTDOWN: state_d = ST_SHUTDOWN;
                        default:      state_d = ST_RUN;
                    endcase
                end
            end
            ST_LPRUN: begin
                if (mode_enter) begin
                    case (mode_req)
                        REQ_RUN:      state_d = ST_RUN;
                        REQ_LPSLEEP:  state_d = ST_LPSLEEP;
                        REQ_STOP1:    state_d = ST_STOP1;
                        REQ_STOP2:    state_d = ST_STOP2;
                        REQ_STANDBY:  state_d = ST_STANDBY;
                        REQ_SHUTDOWN: state_d = ST_SHUTDOWN;
                        default:      state_d = ST_LPRUN;
                    endcase
                end
            end
            ST_SLEEP:   if (wake_hit) state_d = ST_RUN;
            ST_LPSLEEP: if (wake_hit) state_d = ST_LPRUN;
            ST_STOP0, ST_STOP1, ST_STOP2: begin
                if (wake_hit) begin
                    state_d = ST_STOPWAKE;
                    cnt_d   = CNT_W'(STOP_WAKE_CYC - 1);
                end
            end
            ST_STANDBY, ST_SHUTDOWN: begin
                if (wake_hit) begin
                    state_d = ST_RSTSEQ;
                    cnt_d   = CNT_W'(RST_CYC - 1);
                end
            end
            ST_STOPWAKE, ST_RSTSEQ: begin
                if (cnt_q == '0) state_d = ST_RUN;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Moore outputs: supply and clock plan per state
    always_comb begin
        main_reg_en  = 1'b0;
        lp_reg_en    = 1'b0;
        hs_osc_en    = 1'b0;
        ls_osc_en    = 1'b1;
        cpu_clk_en   = 1'b0;
        ret_bank_en  = 1'b0;
        core_lowleak = 1'b0;
        core_rst_n   = 1'b1;
        unique case (state_q)
            ST_RUN:      begin main_reg_en = 1'b1; hs_osc_en = 1'b1; cpu_clk_en = 1'b1; end
            ST_LPRUN:    begin lp_reg_en = 1'b1;   hs_osc_en = 1'b1; cpu_clk_en = 1'b1; end
            ST_SLEEP:    begin main_reg_en = 1'b1; hs_osc_en = 1'b1; end
            ST_LPSLEEP:  begin lp_reg_en = 1'b1;   hs_osc_en = 1'b1; end
            ST_STOP0:    main_reg_en = 1'b1;
            ST_STOP1:    lp_reg_en = 1'b1;
            ST_STOP2:    begin lp_reg_en = 1'b1; core_lowleak = 1'b1; end
            ST_STANDBY:  begin lp_reg_en = cfg_ret_bank; ret_bank_en = cfg_ret_bank; end
            ST_SHUTDOWN: ls_osc_en = 1'b0;
            ST_STOPWAKE: begin main_reg_en = 1'b1; hs_osc_en = 1'b1; end
            ST_RSTSEQ:   begin main_reg_en = 1'b1; hs_osc_en = 1'b1; core_rst_n = 1'b0; end
            default:     begin main_reg_en = 1'b1; hs_osc_en = 1'b1; end
        endcase
    end
endmodule

// File: rtl/lpm_clk_sel.sv
module lpm_clk_sel
    import lpm_pkg::*;
#(
    parameter int MHZ_W          = 7,
    parameter int RESET_MHZ      = 4,
    parameter int STOP_MULTI_MHZ = 48,
    parameter int FIXED16_MHZ    = 16,
    parameter int STBY_WAKE_MHZ  = 8,
    parameter int SHDN_WAKE_MHZ  = 4,
    parameter int LPRUN_CAP_MHZ  = 2,
    parameter int SLOW_CAP_MHZ   = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lpm_state_e       state_q,
    input  lpm_state_e       state_d,
    input  logic             cfg_stop_fixed16,
    input  logic             cfg_slow_range,
    output logic             clk_src,
    output logic [MHZ_W-1:0] clk_mhz
);
    localparam logic [MHZ_W-1:0] LP_CAP   = MHZ_W'(LPRUN_CAP_MHZ);
    localparam logic [MHZ_W-1:0] SLOW_CAP = MHZ_W'(SLOW_CAP_MHZ);

    logic             base_src;
    logic [MHZ_W-1:0] base_mhz;
    logic             wake_from_stop;

    assign wake_from_stop = (state_d == ST_STOPWAKE) && (state_q != ST_STOPWAKE);

    // Clock selection is latched on the wake transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_src <= CK_MULTI;
            base_mhz <= MHZ_W'(RESET_MHZ);
        end else if (wake_from_stop) begin
            base_src <= cfg_stop_fixed16 ? CK_FIXED16 : CK_MULTI;
            base_mhz <= cfg_stop_fixed16 ? MHZ_W'(FIXED16_MHZ) : MHZ_W'(STOP_MULTI_MHZ);
        end else if (state_q == ST_STANDBY && state_d == ST_RSTSEQ) begin
            base_src <= CK_MULTI;
            base_mhz <= MHZ_W'(STBY_WAKE_MHZ);
        end else if (state_q == ST_SHUTDOWN && state_d == ST_RSTSEQ) begin
            base_src <= CK_MULTI;
            base_mhz <= MHZ_W'(SHDN_WAKE_MHZ);
        end
    end

    assign clk_src = base_src;

    always_comb begin
        unique case (state_q)
            ST_LPRUN, ST_LPSLEEP:
                clk_mhz = (base_mhz > LP_CAP) ? LP_CAP : base_mhz;
            ST_RUN, ST_SLEEP, ST_STOPWAKE, ST_RSTSEQ:
                clk_mhz = (cfg_slow_range && base_mhz > SLOW_CAP) ? SLOW_CAP : base_mhz;
            default:
                clk_mhz = '0;
        endcase
    end
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int STOP_WAKE_CYC  = 4,
    parameter int RST_CYC        = 8,
    parameter int MHZ_W          = 7,
    parameter int RESET_MHZ      = 4,
    parameter int STOP_MULTI_MHZ = 48,
    parameter int FIXED16_MHZ    = 16,
    parameter int STBY_WAKE_MHZ  = 8,
    parameter int SHDN_WAKE_MHZ  = 4,
    parameter int LPRUN_CAP_MHZ  = 2,
    parameter int SLOW_CAP_MHZ   = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_enter,
    input  logic [3:0]       mode_req,
    input  logic             wk_irq,
    input  logic             wk_evt,
    input  logic             wk_pin,
    input  logic             wk_rst_pin,
    input  logic             wk_rtc,
    input  logic             wk_wdg,
    input  logic             cfg_pin_rise,
    input  logic             cfg_ret_bank,
    input  logic             cfg_stop_fixed16,
    input  logic             cfg_slow_range,
    output logic             main_reg_en,
    output logic             lp_reg_en,
    output logic             hs_osc_en,
    output logic             ls_osc_en,
    output logic             cpu_clk_en,
    output logic             ret_bank_en,
    output logic             core_lowleak,
    output logic             core_rst_n,
    output logic             clk_src,
    output logic [MHZ_W-1:0] clk_mhz
);
    lpm_state_e state_q, state_d;
    logic       wake_hit;

    lpm_wake_filter u_wake (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_q      (state_q),
        .wk_irq       (wk_irq),
        .wk_evt       (wk_evt),
        .wk_pin       (wk_pin),
        .wk_rst_pin   (wk_rst_pin),
        .wk_rtc       (wk_rtc),
        .wk_wdg       (wk_wdg),
        .cfg_pin_rise (cfg_pin_rise),
        .wake_hit     (wake_hit)
    );

    lpm_fsm #(
        .STOP_WAKE_CYC (STOP_WAKE_CYC),
        .RST_CYC       (RST_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_enter   (mode_enter),
        .mode_req     (mode_req),
        .wake_hit     (wake_hit),
        .cfg_ret_bank (cfg_ret_bank),
        .state_q      (state_q),
        .state_d      (state_d),
        .main_reg_en  (main_reg_en),
        .lp_reg_en    (lp_reg_en),
        .hs_osc_en    (hs_osc_en),
        .ls_osc_en    (ls_osc_en),
        .cpu_clk_en   (cpu_clk_en),
        .ret_bank_en  (ret_bank_en),
        .core_lowleak (core_lowleak),
        .core_rst_n   (core_rst_n)
    );

    lpm_clk_sel #(
        .MHZ_W          (MHZ_W),
        .RESET_MHZ      (RESET_MHZ),
        .STOP_MULTI_MHZ (STOP_MULTI_MHZ),
        .FIXED16_MHZ    (FIXED16_MHZ),
        .STBY_WAKE_MHZ  (STBY_WAKE_MHZ),
        .SHDN_WAKE_MHZ  (SHDN_WAKE_MHZ),
        .LPRUN_CAP_MHZ  (LPRUN_CAP_MHZ),
        .SLOW_CAP_MHZ   (SLOW_CAP_MHZ)
    ) u_clk (
        .clk              (clk),
        .rst_n            (rst_n),
        .state_q          (state_q),
        .state_d          (state_d),
        .cfg_stop_fixed16 (cfg_stop_fixed16),
        .cfg_slow_range   (cfg_slow_range),
        .clk_src          (clk_src),
        .clk_mhz          (clk_mhz)
    );
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk #(
    parameter int MHZ_W         = 7,
    parameter int STBY_WAKE_MHZ = 8,
    parameter int SHDN_WAKE_MHZ = 4,
    parameter int LPRUN_CAP_MHZ = 2,
    parameter int SLOW_CAP_MHZ  = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_stop_fixed16,
    input logic             cfg_slow_range,
    input logic             main_reg_en,
    input logic             lp_reg_en,
    input logic             hs_osc_en,
    input logic             ls_osc_en,
    input logic             cpu_clk_en,
    input logic             core_rst_n,
    input logic             clk_src,
    input logic [MHZ_W-1:0] clk_mhz
);
    // R3: the low-power sleep pattern begins only right after low-power run
    p_lpsleep_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((lp_reg_en && hs_osc_en && !cpu_clk_en) && !$past(lp_reg_en && hs_osc_en && !cpu_clk_en))
        |-> $past(lp_reg_en && cpu_clk_en));

    // R3: low-power regulator with a live clock never exceeds the cap
    p_lp_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_reg_en && hs_osc_en) |-> (clk_mhz <= MHZ_W'(LPRUN_CAP_MHZ)));

    // R5: the slow range caps the frequency on the main regulator
    p_slow_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (main_reg_en && hs_osc_en && cfg_slow_range) |-> (clk_mhz <= MHZ_W'(SLOW_CAP_MHZ)));

    // R4: the CPU clock runs only with oscillators up and the core out of reset
    p_cpu_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> (hs_osc_en && core_rst_n));

    // R8: the stop-wake clock follows the configuration of the wake cycle
    p_stop_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_osc_en) && core_rst_n) |-> (clk_src == $past(cfg_stop_fixed16)));

    // R10: shutdown is left only through the reset sequence
    p_shdn_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ls_osc_en |=> (!ls_osc_en || !core_rst_n));

    // R11: the reset sequence starts only from a powered-down core
    p_rst_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_n) |-> $past(!main_reg_en && !hs_osc_en));

    // R11: the wake frequency depends on which deep mode was left
    p_rst_clk_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_n) |->
            (clk_mhz == ($past(ls_osc_en) ? MHZ_W'(STBY_WAKE_MHZ) : MHZ_W'(SHDN_WAKE_MHZ))));
endmodule

bind lpm_seq lpm_seq_chk #(
    .MHZ_W         (MHZ_W),
    .STBY_WAKE_MHZ (STBY_WAKE_MHZ),
    .SHDN_WAKE_MHZ (SHDN_WAKE_MHZ),
    .LPRUN_CAP_MHZ (LPRUN_CAP_MHZ),
    .SLOW_CAP_MHZ  (SLOW_CAP_MHZ)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_stop_fixed16 (cfg_stop_fixed16),
    .cfg_slow_range   (cfg_slow_range),
    .main_reg_en      (main_reg_en),
    .lp_reg_en        (lp_reg_en),
    .hs_osc_en        (hs_osc_en),
    .ls_osc_en        (ls_osc_en),
    .cpu_clk_en       (cpu_clk_en),
    .core_rst_n       (core_rst_n),
    .clk_src          (clk_src),
    .clk_mhz          (clk_mhz)
);

// File: tb/tb_lpm_seq.sv
module tb_lpm_seq;
    localparam int CLK_PERIOD = 10;
    localparam int STOPC = 4;
    localparam int RSTC  = 8;

    localparam int S_RUN = 0, S_LPRUN = 1, S_SLEEP = 2, S_LPSLEEP = 3, S_STOP0 = 4,
                   S_STOP1 = 5, S_STOP2 = 6, S_STBY = 7, S_SHDN = 8, S_SWAKE = 9, S_RSTQ = 10;
    localparam logic [5:0] W_IRQ = 6'd32, W_EVT = 6'd16, W_PIN = 6'd8,
                           W_RSTP = 6'd4, W_RTC = 6'd2, W_WDG = 6'd1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_enter = 1'b0;
    logic [3:0] mode_req = '0;
    logic wk_irq = 0, wk_evt = 0, wk_pin = 0, wk_rst_pin = 0, wk_rtc = 0, wk_wdg = 0;
    logic cfg_pin_rise = 1'b1, cfg_ret_bank = 1'b0, cfg_stop_fixed16 = 1'b0, cfg_slow_range = 1'b0;
    logic main_reg_en, lp_reg_en, hs_osc_en, ls_osc_en, cpu_clk_en, ret_bank_en,
          core_lowleak, core_rst_n, clk_src;
    logic [6:0] clk_mhz;

    lpm_seq #(.STOP_WAKE_CYC(STOPC), .RST_CYC(RSTC)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, bad = 0;
    bit done = 1'b0;
    int m = S_RUN, cnt = 0, base_mhz = 4;
    bit base_src = 1'b0, pin_prev = 1'b0;

    function automatic logic [7:0] exp_en(int s, bit ret);
        case (s) // {main,lp,hs,ls,cpu,ret,lowleak,rstn}
            S_RUN:     return 8'b1011_1001;
            S_LPRUN:   return 8'b0111_1001;
            S_SLEEP:   return 8'b1011_0001;
            S_LPSLEEP: return 8'b0111_0001;
            S_STOP0:   return 8'b1001_0001;
            S_STOP1:   return 8'b0101_0001;
            S_STOP2:   return 8'b0101_0011;
            S_STBY:    return {1'b0, ret, 2'b01, 1'b0, ret, 2'b01};
            S_SHDN:    return 8'b0000_0001;
            S_SWAKE:   return 8'b1011_0001;
            default:   return 8'b1011_0000;
        endcase
    endfunction

    function automatic int exp_mhz(int s, int base, bit slow);
        if (s == S_LPRUN || s == S_LPSLEEP) return (base > 2) ? 2 : base;
        if (s == S_RUN || s == S_SLEEP || s == S_SWAKE || s == S_RSTQ)
            return (slow && base > 26) ? 26 : base;
        return 0;
    endfunction

    function automatic string tag_of(int s);
        case (s)
            S_RUN: return "R1";
            S_LPRUN, S_LPSLEEP: return "R3";
            S_SLEEP: return "R4";
            S_STOP0, S_STOP1, S_STOP2: return "R6";
            S_SWAKE: return "R7";
            S_STBY: return "R9";
            S_SHDN: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare the DUT with a hand-stated mode, frequency and source
    task automatic want(int s, int mhz, bit src, string tag);
        check(tag, int'({main_reg_en, lp_reg_en, hs_osc_en, ls_osc_en, cpu_clk_en,
                         ret_bank_en, core_lowleak, core_rst_n}), int'(exp_en(s, cfg_ret_bank)));
        check(tag, int'(clk_mhz), mhz);
        check(tag, int'(clk_src), int'(src));
    endtask

    task automatic model_step(bit en, logic [3:0] rq, logic [5:0] wk);
        bit pedge;
        pedge = cfg_pin_rise ? (wk[3] && !pin_prev) : (!wk[3] && pin_prev);
        pin_prev = wk[3];
        case (m)
            S_RUN:   if (en && (rq == 1 || rq == 2 || (rq >= 4 && rq <= 8))) m = int'(rq);
            S_LPRUN: if (en && (rq == 0 || rq == 3 || (rq >= 5 && rq <= 8))) m = int'(rq);
            S_SLEEP:   if (wk[5] || wk[4]) m = S_RUN;
            S_LPSLEEP: if (wk[5] || wk[4]) m = S_LPRUN;
            S_STOP0, S_STOP1, S_STOP2:
                if (wk[5] || wk[4] || wk[1]) begin
                    m = S_SWAKE; cnt = STOPC - 1;
                    base_src = cfg_stop_fixed16; base_mhz = cfg_stop_fixed16 ? 16 : 48;
                end
            S_STBY:
                if (wk[2] || wk[0] || pedge || wk[1]) begin
                    m = S_RSTQ; cnt = RSTC - 1; base_src = 0; base_mhz = 8;
                end
            S_SHDN:
                if (wk[2] || pedge || wk[1]) begin
                    m = S_RSTQ; cnt = RSTC - 1; base_src = 0; base_mhz = 4;
                end
            default: if (cnt == 0) m = S_RUN; else cnt--;
        endcase
    endtask

    // Drive one cycle at a falling edge, sample at the next falling edge
    task automatic tick(bit en, logic [3:0] rq, logic [5:0] wk);
        mode_enter = en; mode_req = rq;
        {wk_irq, wk_evt, wk_pin, wk_rst_pin, wk_rtc, wk_wdg} = wk;
        model_step(en, rq, wk);
        @(negedge clk);
        want(m, exp_mhz(m, base_mhz, cfg_slow_range), base_src, tag_of(m));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [5:0] wk;
        bit pin;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        want(S_RUN, 4, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        want(S_RUN, 4, 1'b0, "R1");

        tick(1, 4'd3, 0);  want(S_RUN, 4, 0, "R2");
        tick(1, 4'd12, 0); want(S_RUN, 4, 0, "R2");
        tick(1, 4'd2, 0);  want(S_SLEEP, 4, 0, "R4");
        tick(0, 0, W_RTC); want(S_SLEEP, 4, 0, "R4");
        tick(0, 0, W_IRQ); want(S_RUN, 4, 0, "R4");

        tick(1, 4'd1, 0);  want(S_LPRUN, 2, 0, "R3");
        tick(1, 4'd2, 0);  want(S_LPRUN, 2, 0, "R13");
        tick(1, 4'd3, 0);  want(S_LPSLEEP, 2, 0, "R3");
        tick(0, 0, W_EVT); want(S_LPRUN, 2, 0, "R3");
        tick(1, 4'd0, 0);  want(S_RUN, 4, 0, "R13");

        cfg_stop_fixed16 = 1'b1; cfg_pin_rise = 1'b1;
        tick(1, 4'd6, 0);  want(S_STOP2, 0, 0, "R6");
        tick(0, 0, W_PIN); want(S_STOP2, 0, 0, "R7");
        tick(0, 0, W_WDG); want(S_STOP2, 0, 0, "R7");
        tick(0, 0, W_RTC); want(S_SWAKE, 16, 1, "R8");
        repeat (STOPC - 1) tick(0, 0, 0);
        want(S_SWAKE, 16, 1, "R7");
        tick(0, 0, 0);     want(S_RUN, 16, 1, "R7");

        cfg_stop_fixed16 = 1'b0;
        tick(1, 4'd4, 0);  want(S_STOP0, 0, 1, "R6");
        tick(0, 0, W_IRQ); want(S_SWAKE, 48, 0, "R8");
        cfg_slow_range = 1'b1; #1;
        want(S_SWAKE, 26, 0, "R5");
        repeat (STOPC) tick(0, 0, 0);
        want(S_RUN, 26, 0, "R5");

        cfg_ret_bank = 1'b1; cfg_pin_rise = 1'b0;
        tick(1, 4'd7, 0);  want(S_STBY, 0, 0, "R9");
        tick(0, 0, W_IRQ | W_EVT); want(S_STBY, 0, 0, "R9");
        tick(0, 0, W_PIN); want(S_STBY, 0, 0, "R12");
        tick(0, 0, 0);     want(S_RSTQ, 8, 0, "R12");
        repeat (RSTC - 1) tick(0, 0, 0);
        want(S_RSTQ, 8, 0, "R11");
        tick(0, 0, 0);     want(S_RUN, 8, 0, "R11");

        tick(1, 4'd8, 0);  want(S_SHDN, 0, 0, "R10");
        tick(0, 0, W_WDG); want(S_SHDN, 0, 0, "R10");
        tick(0, 0, W_RSTP); want(S_RSTQ, 4, 0, "R11");
        repeat (RSTC) tick(0, 0, 0);
        want(S_RUN, 4, 0, "R11");

        // Random phase: strobes, wakes and configuration collide freely
        pin = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            if (i % 64 == 0) begin
                cfg_pin_rise     = $urandom % 2;
                cfg_ret_bank     = $urandom % 2;
                cfg_stop_fixed16 = $urandom % 2;
                cfg_slow_range   = $urandom % 2;
            end
            if ($urandom % 8 == 0) cfg_stop_fixed16 = ~cfg_stop_fixed16;
            if ($urandom % 4 == 0) pin = ~pin;
            wk = '0;
            wk[5] = ($urandom % 10 == 0);
            wk[4] = ($urandom % 12 == 0);
            wk[3] = pin;
            wk[2] = ($urandom % 30 == 0);
            wk[1] = ($urandom % 14 == 0);
            wk[0] = ($urandom % 14 == 0);
            tick(($urandom % 3 == 0), 4'($urandom % 16), wk);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule